// File: doc/BRIEF.md
# Single-Wire Slave Command-Level Sequencer

This block is the protocol sequencer on the device side of a single-wire serial memory slave. It watches the sampled bus line and times every low pulse. A pulse long enough to count as a bus reset returns the block to its first command level. A very long pulse also makes the block pull the line low itself for a set time, after a set delay, to announce that it is present. Its own pull-down is kept out of the pulse timing.

Command bytes come from a bit-level receiver over a valid/ready byte interface. The sequencer decodes two levels of command. The first level is a serial-number command: read, match or skip. Read sends the stored serial number out over a valid/ready transmit byte interface. Match compares the next bytes against the stored serial number. The second level is a memory-function command, which the sequencer decodes and holds for the memory datapath. Opcode 55h has one meaning at each level. Only a bus reset leaves the second level or the idle state that an unknown opcode or a failed match leads to.

Top module: `owseq_top`

## Requirements
- R1: After `rst_n` is released, `pres_drive`, `tx_valid`, `dev_sel`, `rom_sel` and `mem_op` are 0. The block stays idle and decodes no command until a bus reset. While idle it keeps `rx_ready` at 1 and drops the bytes it receives.
- R2: A low pulse of more than `LOW_LONG_CYC` cycles is a bus reset. Counting the first rising clock edge at which the line is high as edge 1, `pres_drive` rises on edge `PP_WAIT_CYC+SYNC_STAGES+2` and stays high for exactly `PP_LEN_CYC` cycles.
- R3: A low pulse of more than `LOW_SHORT_CYC` and at most `LOW_LONG_CYC` cycles returns the block to the first level. It clears `dev_sel`, `rom_sel` and `mem_op`, and it produces no presence drive.
- R4: A low pulse of at most `LOW_SHORT_CYC` cycles has no effect on any output.
- R5: Cycles in which the block drives its own presence pulse are never counted as line-low time, so a presence pulse longer than `LOW_LONG_CYC` does not cause a second reset or a second presence pulse.
- R6: Byte CCh at the first level sets `dev_sel`=1 and `rom_sel`=3 and moves the block to the second level.
- R7: Byte 33h at the first level sets `rom_sel`=1 and sends the `SN_BYTES` serial-number bytes, least significant byte first. `tx_data` is held with `tx_valid` until `tx_ready` is seen. `rx_ready` is 0 while sending. After the last byte, `dev_sel`=1 and the block is at the second level.
- R8: Byte 55h at the first level sets `rom_sel`=2 and compares the next `SN_BYTES` received bytes, least significant first, with the serial number. A full match sets `dev_sel`=1 and moves the block to the second level.
- R9: On the first byte that does not match, the block goes idle with `dev_sel`=0 and ignores all bytes until a bus reset.
- R10: At the second level, F0h, AAh, 0Fh and 55h set `mem_op` to 1 (read memory), 2 (read status), 3 (write memory) and 4 (write status) respectively. `mem_op` then holds and `rx_ready` is 0 until a bus reset.
- R11: Any other byte at either level makes the block idle with `dev_sel`=0. This includes a second-level opcode received at the first level and a first-level opcode received at the second level. Only a bus reset leaves the idle state.
- R12: `mem_op` is nonzero only while `dev_sel` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | 1 | Sampled bus line level, 1 = released |
| pres_drive | output | 1 | Request to pull the line low for the presence pulse |
| rx_valid | input | 1 | Received byte available |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Sequencer accepts the received byte |
| tx_valid | output | 1 | Serial-number byte to send is available |
| tx_data | output | 8 | Serial-number byte to send |
| tx_ready | input | 1 | Bit-level sender takes the byte |
| rom_sel | output | 2 | First-level command taken: 0 none, 1 read, 2 match, 3 skip |
| dev_sel | output | 1 | Device addressed, second level reached |
| mem_op | output | 3 | Decoded memory operation, 0 none, 1 to 4 as in R10 |

## Verification
The checks on the transmit side assume that the sender keeps `tx_ready` free of glitches and only uses it to take bytes. They also assume that the line is the wired-AND of the host and the block's own presence drive. The bench models the line as exactly that, and it toggles `tx_ready` on a fixed pattern during the serial-number read. Receive bytes are only offered while the bus is idle and never during a low pulse. The bench never offers a byte while the block is at the second level after decoding an operation, because `rx_ready` stays low there.

// File: rtl/owseq_pkg.sv
package owseq_pkg;

   typedef enum logic [2:0] {
      OP_NONE    = 3'd0,
      OP_RD_MEM  = 3'd1,
      OP_RD_STAT = 3'd2,
      OP_WR_MEM  = 3'd3,
      OP_WR_STAT = 3'd4
   } mem_op_t;

   typedef enum logic [1:0] {
      RS_NONE  = 2'd0,
      RS_READ  = 2'd1,
      RS_MATCH = 2'd2,
      RS_SKIP  = 2'd3
   } rom_sel_t;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_ROM_CMD,
      SQ_MATCH,
      SQ_ROM_TX,
      SQ_FN_CMD,
      SQ_FN_RUN
   } seq_state_t;

   typedef enum logic [1:0] {
      PR_OFF,
      PR_WAIT,
      PR_DRIVE
   } pres_state_t;

   localparam logic [7:0] CODE_ROM_READ  = 8'h33;
   localparam logic [7:0] CODE_ROM_MATCH = 8'h55;
   localparam logic [7:0] CODE_ROM_SKIP  = 8'hCC;
   localparam logic [7:0] CODE_FN_RDMEM  = 8'hF0;
   localparam logic [7:0] CODE_FN_RDSTAT = 8'hAA;
   localparam logic [7:0] CODE_FN_WRMEM  = 8'h0F;
   localparam logic [7:0] CODE_FN_WRSTAT = 8'h55;

endpackage

// File: rtl/owseq_low_timer.sv
module owseq_low_timer #(
   parameter int SYNC_STAGES   = 2,
   parameter int LOW_SHORT_CYC = 120,
   parameter int LOW_LONG_CYC  = 480
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   input  logic self_drive,
   output logic rst_evt,
   output logic rst_long
);
   localparam int CW = $clog2(LOW_LONG_CYC + 2);
   localparam logic [CW-1:0] SAT   = CW'(LOW_LONG_CYC + 1);
   localparam logic [CW-1:0] SHORT = CW'(LOW_SHORT_CYC);
   localparam logic [CW-1:0] LONG  = CW'(LOW_LONG_CYC);

   if (LOW_SHORT_CYC < 1) begin : g_bad_short
      $error("LOW_SHORT_CYC must be at least 1");
   end
   if (LOW_LONG_CYC <= LOW_SHORT_CYC) begin : g_bad_long
      $error("LOW_LONG_CYC must exceed LOW_SHORT_CYC");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must lie in 0..4");
   end

   logic line_s;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign line_s = line_in;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= '1;
         else        sh <= {sh[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], line_in} & {SYNC_STAGES{1'b1}};
      end
      assign line_s = sh[SYNC_STAGES-1];
   end

   logic [CW-1:0] low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt  <= '0;
         rst_evt  <= 1'b0;
         rst_long <= 1'b0;
      end else begin
         rst_evt  <= 1'b0;
         rst_long <= 1'b0;
         if (self_drive) begin
            low_cnt <= '0;
         end else if (!line_s) begin
            if (low_cnt != SAT) low_cnt <= low_cnt + 1'b1;
         end else if (low_cnt != '0) begin
            rst_evt  <= (low_cnt > SHORT);
            rst_long <= (low_cnt > LONG);
            low_cnt  <= '0;
         end
      end
   end

endmodule

// File: rtl/owseq_presence.sv
module owseq_presence #(
   parameter int PP_WAIT_CYC = 30,
   parameter int PP_LEN_CYC  = 150
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rst_evt,
   input  logic rst_long,
   output logic pres_drive
);
   import owseq_pkg::*;

   localparam int MAXC = (PP_WAIT_CYC > PP_LEN_CYC) ? PP_WAIT_CYC : PP_LEN_CYC;
   localparam int PW   = $clog2(MAXC + 1);
   localparam logic [PW-1:0] WAIT_LAST = PW'(PP_WAIT_CYC - 1);
   localparam logic [PW-1:0] LEN_LAST  = PW'(PP_LEN_CYC - 1);

   if (PP_WAIT_CYC < 1 || PP_LEN_CYC < 1) begin : g_bad_pp
      $error("presence delay and length must be at least 1");
   end

   pres_state_t   st;
   logic [PW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= PR_OFF;
         cnt <= '0;
      end else if (rst_evt) begin
         st  <= rst_long ? PR_WAIT : PR_OFF;
         cnt <= '0;
      end else begin
         case (st)
            PR_WAIT: begin
               if (cnt == WAIT_LAST) begin
                  st  <= PR_DRIVE;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PR_DRIVE: begin
               if (cnt == LEN_LAST) begin
                  st  <= PR_OFF;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: cnt <= '0;
         endcase
      end
   end

   assign pres_drive = (st == PR_DRIVE);

endmodule

// File: rtl/owseq_cmd_fsm.sv
module owseq_cmd_fsm #(
   parameter int SN_BYTES = 8,
   parameter logic [8*SN_BYTES-1:0] SERIAL = '0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_rst,
   input  logic       rx_valid,
   input  logic [7:0] rx_data,
   output logic       rx_ready,
   output logic       tx_valid,
   output logic [7:0] tx_data,
   input  logic       tx_ready,
   output logic [1:0] rom_sel,
   output logic       dev_sel,
   output logic [2:0] mem_op
);
   import owseq_pkg::*;

   localparam int IW = (SN_BYTES > 1) ? $clog2(SN_BYTES) : 1;
   localparam logic [IW-1:0] LAST = IW'(SN_BYTES - 1);

   if (SN_BYTES < 1) begin : g_bad_sn
      $error("SN_BYTES must be at least 1");
   end

   logic [7:0] sn_b [SN_BYTES];
   for (genvar g = 0; g < SN_BYTES; g++) begin : g_snb
      assign sn_b[g] = SERIAL[8*g +: 8];
   end

   seq_state_t st;
   logic [IW-1:0] idx;
   rom_sel_t rs;
   mem_op_t  op;
   logic     sel;
   logic     take;

   assign take = rx_valid && rx_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= SQ_IDLE;
         idx <= '0;
         rs  <= RS_NONE;
         op  <= OP_NONE;
         sel <= 1'b0;
      end else if (bus_rst) begin
         st  <= SQ_ROM_CMD;
         idx <= '0;
         rs  <= RS_NONE;
         op  <= OP_NONE;
         sel <= 1'b0;
      end else begin
         case (st)
            SQ_ROM_CMD: if (take) begin
               idx <= '0;
               case (rx_data)
                  CODE_ROM_READ: begin
                     st <= SQ_ROM_TX;
                     rs <= RS_READ;
                  end
                  CODE_ROM_MATCH: begin
                     st <= SQ_MATCH;
                     rs <= RS_MATCH;
                  end
                  CODE_ROM_SKIP: begin
                     st  <= SQ_FN_CMD;
                     rs  <= RS_SKIP;
                     sel <= 1'b1;
                  end
                  default: st <= SQ_IDLE;
               endcase
            end
            SQ_MATCH: if (take) begin
               if (rx_data != sn_b[idx]) begin
                  st <= SQ_IDLE;
               end else if (idx == LAST) begin
                  st  <= SQ_FN_CMD;
                  sel <= 1'b1;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            SQ_ROM_TX: if (tx_ready) begin
               if (idx == LAST) begin
                  st  <= SQ_FN_CMD;
                  sel <= 1'b1;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            SQ_FN_CMD: if (take) begin
               st <= SQ_FN_RUN;
               case (rx_data)
                  CODE_FN_RDMEM:  op <= OP_RD_MEM;
                  CODE_FN_RDSTAT: op <= OP_RD_STAT;
                  CODE_FN_WRMEM:  op <= OP_WR_MEM;
                  CODE_FN_WRSTAT: op <= OP_WR_STAT;
                  default: begin
                     st  <= SQ_IDLE;
                     sel <= 1'b0;
                  end
               endcase
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      case (st)
         SQ_IDLE, SQ_ROM_CMD, SQ_MATCH, SQ_FN_CMD: rx_ready = 1'b1;
         default:                                  rx_ready = 1'b0;
      endcase
   end

   assign tx_valid = (st == SQ_ROM_TX);
   assign tx_data  = sn_b[idx];
   assign rom_sel  = rs;
   assign dev_sel  = sel;
   assign mem_op   = op;

endmodule

// File: rtl/owseq_top.sv
module owseq_top #(
   parameter int SYNC_STAGES   = 2,
   parameter int LOW_SHORT_CYC = 120,
   parameter int LOW_LONG_CYC  = 480,
   parameter int PP_WAIT_CYC   = 30,
   parameter int PP_LEN_CYC    = 150,
   parameter int SN_BYTES      = 8,
   parameter logic [8*SN_BYTES-1:0] SERIAL = 64'h1CA55A3C0FE1772D
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       line_in,
   output logic       pres_drive,
   input  logic       rx_valid,
   input  logic [7:0] rx_data,
   output logic       rx_ready,
   output logic       tx_valid,
   output logic [7:0] tx_data,
   input  logic       tx_ready,
   output logic [1:0] rom_sel,
   output logic       dev_sel,
   output logic [2:0] mem_op
);
   logic evt_w;
   logic long_w;

   owseq_low_timer #(
      .SYNC_STAGES  (SYNC_STAGES),
      .LOW_SHORT_CYC(LOW_SHORT_CYC),
      .LOW_LONG_CYC (LOW_LONG_CYC)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_in   (line_in),
      .self_drive(pres_drive),
      .rst_evt   (evt_w),
      .rst_long  (long_w)
   );

   owseq_presence #(
      .PP_WAIT_CYC(PP_WAIT_CYC),
      .PP_LEN_CYC (PP_LEN_CYC)
   ) u_pres (
      .clk       (clk),
      .rst_n     (rst_n),
      .rst_evt   (evt_w),
      .rst_long  (long_w),
      .pres_drive(pres_drive)
   );

   owseq_cmd_fsm #(
      .SN_BYTES(SN_BYTES),
      .SERIAL  (SERIAL)
   ) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .bus_rst (evt_w),
      .rx_valid(rx_valid),
      .rx_data (rx_data),
      .rx_ready(rx_ready),
      .tx_valid(tx_valid),
      .tx_data (tx_data),
      .tx_ready(tx_ready),
      .rom_sel (rom_sel),
      .dev_sel (dev_sel),
      .mem_op  (mem_op)
   );

endmodule

// File: rtl/owseq_chk.sv
module owseq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       rst_evt,
   input logic       rst_long,
   input logic       pres_drive,
   input logic       rx_ready,
   input logic       tx_valid,
   input logic [7:0] tx_data,
   input logic       tx_ready,
   input logic [1:0] rom_sel,
   input logic       dev_sel,
   input logic [2:0] mem_op
);

   // R12
   op_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_op != 3'd0) |-> dev_sel);

   // R3
   short_no_pres_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_evt && !rst_long) |=> !pres_drive);

   // R2
   pres_at_rom_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pres_drive) |-> (rom_sel == 2'd0 && !dev_sel && mem_op == 3'd0));

   // R1
   evt_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_evt |=> (mem_op == 3'd0 && !dev_sel && rom_sel == 2'd0));

   // R7
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready && !rst_evt) |=> (tx_valid && $stable(tx_data)));

   // R7
   tx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> !rx_ready);

   // R10
   op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_op != 3'd0 && !rst_evt) |=> (mem_op == $past(mem_op)));

   // R10
   run_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_op != 3'd0) |-> !rx_ready);

endmodule

bind owseq_top owseq_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rst_evt   (evt_w),
   .rst_long  (long_w),
   .pres_drive(pres_drive),
   .rx_ready  (rx_ready),
   .tx_valid  (tx_valid),
   .tx_data   (tx_data),
   .tx_ready  (tx_ready),
   .rom_sel   (rom_sel),
   .dev_sel   (dev_sel),
   .mem_op    (mem_op)
);

// File: tb/sim_owseq_top.sv
`timescale 1ns/100ps
module sim_owseq_top;
   localparam int S   = 2;
   localparam int SH  = 40;
   localparam int LG  = 160;
   localparam int W   = 12;
   localparam int L   = 170;
   localparam int NB  = 8;
   localparam logic [8*NB-1:0] SN = 64'h1CA55A3C0FE1772D;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_line = 1'b1;
   logic rx_valid = 1'b0;
   logic [7:0] rx_data = 8'h00;
   logic tx_ready = 1'b0;
   logic pres_drive, rx_ready, tx_valid, dev_sel;
   logic [7:0] tx_data;
   logic [1:0] rom_sel;
   logic [2:0] mem_op;
   wire line_in = host_line & ~pres_drive;

   int total = 0;
   int bad = 0;
   int pres_rises = 0;
   bit pd_q = 1'b0;
   bit done = 1'b0;
   logic [7:0] exp_q[$];

   always #2.5 clk = ~clk;

   owseq_top #(
      .SYNC_STAGES(S), .LOW_SHORT_CYC(SH), .LOW_LONG_CYC(LG),
      .PP_WAIT_CYC(W), .PP_LEN_CYC(L), .SN_BYTES(NB), .SERIAL(SN)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .line_in(line_in), .pres_drive(pres_drive),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
      .rom_sel(rom_sel), .dev_sel(dev_sel), .mem_op(mem_op)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // monitor: presence rise counter and transmit scoreboard
   always begin
      @(negedge clk);
      #1;
      if (pres_drive && !pd_q) pres_rises++;
      pd_q = pres_drive;
      if (tx_valid && tx_ready) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R7 unexpected tx byte", tx_data, -1);
         end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(tx_data == e, "R7 tx byte order", tx_data, e);
         end
      end
   end

   task automatic low_pulse(input int n);
      @(negedge clk);
      host_line = 1'b0;
      repeat (n) @(negedge clk);
      host_line = 1'b1;
   endtask

   task automatic short_reset();
      low_pulse(60);
      repeat (S + 4) @(negedge clk);
   endtask

   task automatic send(input logic [7:0] b);
      int k;
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = b;
      k = 0;
      while (!rx_ready && k < 50) begin
         @(negedge clk);
         k++;
      end
      if (!rx_ready) chk(1'b0, "send: rx_ready never rose", 0, 1);
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(pres_drive == 0 && tx_valid == 0, "R1 drives idle", {pres_drive, tx_valid}, 0);
      chk(dev_sel == 0 && rom_sel == 0 && mem_op == 0, "R1 status clear", {dev_sel, rom_sel, mem_op}, 0);
      send(8'hCC);
      repeat (2) @(negedge clk);
      chk(dev_sel == 0 && rom_sel == 0, "R1 no decode before bus reset", {dev_sel, rom_sel}, 0);

      // R2 long reset and presence timing
      begin
         int n;
         int len;
         low_pulse(500);
         n = 0;
         while (n < 200) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (pres_drive) break;
         end
         chk(n == W + S + 2, "R2 presence delay", n, W + S + 2);
         len = 1;
         while (len < 1000) begin
            @(negedge clk);
            if (pres_drive) len++;
            else break;
         end
         chk(len == L, "R2 presence length", len, L);
         n = pres_rises;
         repeat (400) @(negedge clk);
         chk(pres_rises == n, "R5 own drive not a reset", pres_rises - n, 0);
      end

      // R6 skip
      send(8'hCC);
      repeat (2) @(negedge clk);
      chk(dev_sel == 1 && rom_sel == 3, "R6 skip selects", {dev_sel, rom_sel}, 7);

      // R3 short reset
      begin
         int r0;
         r0 = pres_rises;
         low_pulse(100);
         repeat (S + 60) @(negedge clk);
         chk(pres_rises == r0, "R3 no presence", pres_rises - r0, 0);
         chk(dev_sel == 0 && rom_sel == 0, "R3 back to first level", {dev_sel, rom_sel}, 0);
      end

      // R10 read memory, R4 ignored short glitch
      send(8'hCC);
      send(8'hF0);
      repeat (2) @(negedge clk);
      chk(mem_op == 1, "R10 F0 read memory", mem_op, 1);
      chk(rx_ready == 0, "R10 not ready while running", rx_ready, 0);
      low_pulse(30);
      repeat (S + 20) @(negedge clk);
      chk(mem_op == 1 && dev_sel == 1, "R4 short glitch ignored", {dev_sel, mem_op}, 9);

      short_reset();
      send(8'hCC);
      send(8'hAA);
      repeat (2) @(negedge clk);
      chk(mem_op == 2, "R10 AA read status", mem_op, 2);

      short_reset();
      send(8'hCC);
      send(8'h0F);
      repeat (2) @(negedge clk);
      chk(mem_op == 3, "R10 0F write memory", mem_op, 3);

      // R7 read serial number with irregular tx_ready
      short_reset();
      for (int i = 0; i < NB; i++) exp_q.push_back(SN[8*i +: 8]);
      send(8'h33);
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         tx_ready = (i % 3) != 1;
      end
      @(negedge clk);
      tx_ready = 1'b0;
      repeat (2) @(negedge clk);
      chk(exp_q.size() == 0, "R7 all bytes sent", exp_q.size(), 0);
      chk(dev_sel == 1 && rom_sel == 1, "R7 read leads to second level", {dev_sel, rom_sel}, 5);
      send(8'h55);
      repeat (2) @(negedge clk);
      chk(mem_op == 4, "R10 55 write status at second level", mem_op, 4);

      // R8 match success
      short_reset();
      send(8'h55);
      for (int i = 0; i < NB; i++) send(SN[8*i +: 8]);
      repeat (2) @(negedge clk);
      chk(dev_sel == 1 && rom_sel == 2, "R8 match selects", {dev_sel, rom_sel}, 6);
      send(8'hAA);
      repeat (2) @(negedge clk);
      chk(mem_op == 2, "R8 function after match", mem_op, 2);

      // R9 mismatch
      short_reset();
      send(8'h55);
      send(SN[7:0]);
      send(SN[15:8]);
      send(SN[23:16] ^ 8'h01);
      for (int i = 3; i < NB; i++) send(SN[8*i +: 8]);
      send(8'hF0);
      repeat (2) @(negedge clk);
      chk(dev_sel == 0 && mem_op == 0, "R9 mismatch stays idle", {dev_sel, mem_op}, 0);
      short_reset();
      send(8'hCC);
      repeat (2) @(negedge clk);
      chk(dev_sel == 1, "R9 reset leaves idle", dev_sel, 1);

      // R11 unknown opcodes
      short_reset();
      send(8'hF0);
      send(8'hCC);
      repeat (2) @(negedge clk);
      chk(dev_sel == 0 && rom_sel == 0, "R11 level-2 code at level 1", {dev_sel, rom_sel}, 0);
      short_reset();
      send(8'hCC);
      send(8'h33);
      send(8'hF0);
      repeat (2) @(negedge clk);
      chk(dev_sel == 0 && mem_op == 0, "R11 level-1 code at level 2", {dev_sel, mem_op}, 0);
      chk(tx_valid == 0, "R11 no serial read at level 2", tx_valid, 0);

      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         done = 1'b1;
         chk(1'b0, "watchdog expired", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule